// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block is the synchronous command interpreter of a parallel NOR flash with 16-bit words and an 18-bit word address. Every bus write arrives as one strobe carrying an address and a data word. The decoder follows the multi-write unlock sequences that guard the destructive operations. A completed program or erase sequence becomes a single-cycle request to the operation engine, carrying the operation type and its target. A completed mode sequence switches what reads return.

While the decoder is in identification mode or query mode, it answers reads from a small built-in table and raises a select flag so that the read path uses this table instead of the array. While the engine reports busy, the decoder ignores every write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (mode_o = 0), start_o is low and rd_sel_o is low.
- R2: Command writes compare only address bits 14:0 and data bits 7:0. Address bits 17:15 and data bits 15:8 do not affect decoding.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by one further write request a program. In the cycle after that fourth write is captured, start_o is high, op_o = 0, and op_addr_o and op_data_o equal the fourth write's address and data.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh followed by 30h at any address request a sector erase. op_o = 1, op_addr_o is the write address with bits 10:0 cleared, and op_data_o = FFFFh.
- R5: The same five writes followed by 50h at any address request a block erase. op_o = 2, op_addr_o has bits 14:0 cleared, and op_data_o = FFFFh.
- R6: The same five writes followed by 10h at 5555h request a chip erase with op_o = 3, op_addr_o = 0 and op_data_o = FFFFh. A 10h sixth write at any other address starts nothing.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h selects identification mode (mode_o = 1, rd_sel_o = 1). In this mode a read at address 0 returns 00BFh, a read at address 1 returns 272Fh, and a read at any other address returns 0.
- R8: AAh@5555h, 55h@2AAAh, 98h@5555h selects query mode (mode_o = 2, rd_sel_o = 1). In this mode reads at 10h, 11h, 12h, 13h and 27h return 0051h, 0052h, 0059h, 0001h and 0013h, and reads at other addresses return 0.
- R9: A single write with low byte F0h at any address while no sequence is open, or AAh@5555h, 55h@2AAAh, F0h@5555h, returns mode_o to array.
- R10: A write that does not match the next expected step of an open sequence closes it, starts nothing and sets mode_o to array. The next write is decoded as a first step.
- R11: While busy_i is high, writes have no effect. They start nothing, leave mode_o unchanged, and neither advance nor close an open sequence.
- R12: start_o is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | One-cycle bus write strobe |
| addr_i | input | 18 | Write word address |
| data_i | input | 16 | Write data |
| busy_i | input | 1 | Operation engine busy; gates command acceptance |
| rd_addr_i | input | 18 | Read address for identification/query reads |
| start_o | output | 1 | One-cycle operation request |
| op_o | output | 2 | Operation: 0 program, 1 sector, 2 block, 3 chip erase |
| op_addr_o | output | 18 | Target address (aligned for erases) |
| op_data_o | output | 16 | Program data, FFFFh for erases |
| mode_o | output | 2 | Read mode: 0 array, 1 identification, 2 query |
| rd_sel_o | output | 1 | High when reads are served by this block |
| rd_data_o | output | 16 | Identification/query read data |

## Verification
The bench targets the cases where a decoder tends to go wrong. Unlock writes with high address bits and a high data byte set catch a design that compares full words, which would never unlock. A chip-erase code written to a non-key address catches a design that decodes the sixth write on data alone, which would start an erase nobody asked for. A broken sequence followed by writes that would have completed it catches a design that does not close the sequence on the bad write, which would program where nothing is asked. An exit command and partial sequences issued while busy catch a design that acts on writes it should ignore, which would leave identification mode or lose its place in a held sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3} op_e;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_ID = 2'd1, RM_CFI = 2'd2} rmode_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ER3, SQ_ER4, SQ_ER5
  } seq_e;

  localparam int unsigned KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_HI = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_LO = 15'h2AAA;

  localparam logic [7:0] C_UNLA  = 8'hAA;
  localparam logic [7:0] C_UNLB  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_IDENT = 8'h90;
  localparam logic [7:0] C_QUERY = 8'h98;
  localparam logic [7:0] C_EXIT  = 8'hF0;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BLK   = 8'h50;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SECT_LSB = 11,
  parameter int unsigned BLK_LSB  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              ev_id_o,
  output logic              ev_cfi_o,
  output logic              ev_exit_o,
  output logic              ev_abort_o
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

  seq_e              state_q, state_d;
  logic              fire;
  op_e               fop;
  logic [ADDR_W-1:0] faddr;
  logic [DATA_W-1:0] fdata;
  logic              acc, hit_hi, hit_lo;
  logic [7:0]        cmd;

  assign acc    = wr_i && !busy_i;
  assign hit_hi = addr_i[KEY_W-1:0] == KEY_HI;
  assign hit_lo = addr_i[KEY_W-1:0] == KEY_LO;
  assign cmd    = data_i[7:0];

  always_comb begin
    state_d    = state_q;
    fire       = 1'b0;
    fop        = OP_PROG;
    faddr      = addr_i;
    fdata      = data_i;
    ev_id_o    = 1'b0;
    ev_cfi_o   = 1'b0;
    ev_exit_o  = 1'b0;
    ev_abort_o = 1'b0;
    if (acc) begin
      unique case (state_q)
        SQ_IDLE: begin
          if (hit_hi && cmd == C_UNLA) state_d = SQ_UNL1;
          else if (cmd == C_EXIT)      ev_exit_o = 1'b1;
        end
        SQ_UNL1: begin
          if (hit_lo && cmd == C_UNLB) state_d = SQ_UNL2;
          else begin state_d = SQ_IDLE; ev_abort_o = 1'b1; end
        end
        SQ_UNL2: begin
          state_d = SQ_IDLE;
          if (!hit_hi) ev_abort_o = 1'b1;
          else begin
            case (cmd)
              C_PROG:  state_d = SQ_PROG;
              C_ERASE: state_d = SQ_ER3;
              C_IDENT: ev_id_o = 1'b1;
              C_QUERY: ev_cfi_o = 1'b1;
              C_EXIT:  ev_exit_o = 1'b1;
              default: ev_abort_o = 1'b1;
            endcase
          end
        end
        SQ_PROG: begin
          state_d = SQ_IDLE;
          fire    = 1'b1;
        end
        SQ_ER3: begin
          if (hit_hi && cmd == C_UNLA) state_d = SQ_ER4;
          else begin state_d = SQ_IDLE; ev_abort_o = 1'b1; end
        end
        SQ_ER4: begin
          if (hit_lo && cmd == C_UNLB) state_d = SQ_ER5;
          else begin state_d = SQ_IDLE; ev_abort_o = 1'b1; end
        end
        SQ_ER5: begin
          state_d = SQ_IDLE;
          fdata   = '1;
          if (hit_hi && cmd == C_CHIP) begin
            fire = 1'b1; fop = OP_CHIP; faddr = '0;
          end else if (cmd == C_SECT) begin
            fire = 1'b1; fop = OP_SECT; faddr = addr_i & SECT_MASK;
          end else if (cmd == C_BLK) begin
            fire = 1'b1; fop = OP_BLK; faddr = addr_i & BLK_MASK;
          end else ev_abort_o = 1'b1;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_IDLE;
      start_o   <= 1'b0;
      op_o      <= OP_PROG;
      op_addr_o <= '0;
      op_data_o <= '0;
    end else begin
      state_q <= state_d;
      start_o <= fire;
      if (fire) begin
        op_o      <= fop;
        op_addr_o <= faddr;
        op_data_o <= fdata;
      end
    end
  end

  p_start_from_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_i && !busy_i));
  p_start_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_busy_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(state_q) && !start_o));
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
  import flash_cmd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ev_id_i,
  input  logic   ev_cfi_i,
  input  logic   ev_exit_i,
  input  logic   ev_abort_i,
  output rmode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_o <= RM_ARRAY;
    else if (ev_exit_i || ev_abort_i) mode_o <= RM_ARRAY;
    else if (ev_id_i)                 mode_o <= RM_ID;
    else if (ev_cfi_i)                mode_o <= RM_CFI;
  end

  p_mode_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h272F
) (
  input  rmode_e            mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_sel_o,
  output logic [DATA_W-1:0] rd_data_o
);
  assign rd_sel_o = mode_i != RM_ARRAY;

  always_comb begin
    rd_data_o = '0;
    if (mode_i == RM_ID) begin
      if (rd_addr_i == ADDR_W'(0))      rd_data_o = MFR_CODE;
      else if (rd_addr_i == ADDR_W'(1)) rd_data_o = DEV_CODE;
    end else if (mode_i == RM_CFI) begin
      if (rd_addr_i == ADDR_W'('h10))      rd_data_o = DATA_W'('h51);
      else if (rd_addr_i == ADDR_W'('h11)) rd_data_o = DATA_W'('h52);
      else if (rd_addr_i == ADDR_W'('h12)) rd_data_o = DATA_W'('h59);
      else if (rd_addr_i == ADDR_W'('h13)) rd_data_o = DATA_W'('h01);
      else if (rd_addr_i == ADDR_W'('h27)) rd_data_o = DATA_W'('h13);
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SECT_LSB = 11,
  parameter int unsigned BLK_LSB  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              start_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        mode_o,
  output logic              rd_sel_o,
  output logic [DATA_W-1:0] rd_data_o
);
  op_e    op_w;
  rmode_e mode_w;
  logic   ev_id, ev_cfi, ev_exit, ev_abort;

  flash_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_seq (
    .clk_i, .rst_ni, .wr_i, .busy_i, .addr_i, .data_i,
    .start_o, .op_o(op_w), .op_addr_o, .op_data_o,
    .ev_id_o(ev_id), .ev_cfi_o(ev_cfi), .ev_exit_o(ev_exit), .ev_abort_o(ev_abort)
  );

  flash_mode_ctl u_mode (
    .clk_i, .rst_ni,
    .ev_id_i(ev_id), .ev_cfi_i(ev_cfi), .ev_exit_i(ev_exit), .ev_abort_i(ev_abort),
    .mode_o(mode_w)
  );

  flash_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .mode_i(mode_w), .rd_addr_i, .rd_sel_o, .rd_data_o
  );

  assign op_o   = op_w;
  assign mode_o = mode_w;

  p_mode_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(wr_i && !busy_i));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 1'b0, rst_ni = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [17:0] addr = '0, rd_addr = '0, op_addr;
  logic [15:0] data = '0, op_data, rd_data;
  logic        start, rd_sel;
  logic [1:0]  op, mode;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni, .wr_i(wr), .addr_i(addr), .data_i(data), .busy_i(busy),
    .rd_addr_i(rd_addr), .start_o(start), .op_o(op), .op_addr_o(op_addr),
    .op_data_o(op_data), .mode_o(mode), .rd_sel_o(rd_sel), .rd_data_o(rd_data)
  );

  function automatic logic [76:0] v(input int r, input logic [17:0] a, input logic [15:0] d,
                                    input bit s, input int o, input logic [17:0] xa,
                                    input logic [15:0] xd, input int m);
    return {r[3:0], a, d, s, o[1:0], xa, xd, m[1:0]};
  endfunction

  localparam int NV = 43;
  // req, addr, data, exp start, op, addr, data, mode
  localparam logic [76:0] VEC [NV] = '{
    v(3, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R3 program
    v(3, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(3, 18'h05555, 16'h00A0, 0, 0, 0, 0, 0),
    v(3, 18'h3ABCD, 16'h1234, 1, 0, 18'h3ABCD, 16'h1234, 0),
    v(2, 18'h3D555, 16'h77AA, 0, 0, 0, 0, 0),   // R2 upper bits set
    v(2, 18'h2AAAA, 16'h1255, 0, 0, 0, 0, 0),
    v(4, 18'h05555, 16'h0080, 0, 0, 0, 0, 0),   // R4 sector erase
    v(4, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),
    v(4, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(4, 18'h2B9F3, 16'h0030, 1, 1, 18'h2B800, 16'hFFFF, 0),
    v(5, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R5 block erase
    v(5, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(5, 18'h05555, 16'h0080, 0, 0, 0, 0, 0),
    v(5, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),
    v(5, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(5, 18'h1ABCD, 16'h0050, 1, 2, 18'h18000, 16'hFFFF, 0),
    v(6, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R6 chip erase
    v(6, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(6, 18'h05555, 16'h0080, 0, 0, 0, 0, 0),
    v(6, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),
    v(6, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(6, 18'h05555, 16'h0010, 1, 3, 18'h00000, 16'hFFFF, 0),
    v(6, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R6 chip code at wrong address
    v(6, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(6, 18'h05555, 16'h0080, 0, 0, 0, 0, 0),
    v(6, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),
    v(6, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(6, 18'h01234, 16'h0010, 0, 0, 0, 0, 0),
    v(7, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R7 id entry
    v(7, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(7, 18'h05555, 16'h0090, 0, 0, 0, 0, 1),
    v(9, 18'h05555, 16'h00AA, 0, 0, 0, 0, 1),   // R9 three-write exit
    v(9, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 1),
    v(9, 18'h05555, 16'h00F0, 0, 0, 0, 0, 0),
    v(8, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),   // R8 query entry
    v(8, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(8, 18'h05555, 16'h0098, 0, 0, 0, 0, 2),
    v(9, 18'h01234, 16'hABF0, 0, 0, 0, 0, 0),   // R9 single-write exit
    v(10, 18'h05555, 16'h00AA, 0, 0, 0, 0, 0),  // R10 abort
    v(10, 18'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
    v(10, 18'h05555, 16'h0012, 0, 0, 0, 0, 0),
    v(10, 18'h05555, 16'h00A0, 0, 0, 0, 0, 0),
    v(10, 18'h00100, 16'h1111, 0, 0, 0, 0, 0)
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic wcyc(input logic [17:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d; busy = b;
    @(negedge clk);
    wr = 1'b0; busy = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mode", mode, 0);
    chk("R1", "start", start, 0);
    chk("R1", "rd_sel", rd_sel, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] e;
      string rq;
      e = VEC[i];
      rq = $sformatf("R%0d vec%0d", e[76:73], i);
      wcyc(e[72:55], e[54:39], 1'b0);
      chk(rq, "start", start, e[38]);
      chk(rq, "mode", mode, e[1:0]);
      if (e[38]) begin
        chk(rq, "op", op, e[37:36]);
        chk(rq, "op_addr", op_addr, e[35:18]);
        chk(rq, "op_data", op_data, e[17:2]);
      end
    end

    // R12: pulse width after a program request
    wcyc(18'h05555, 16'h00AA, 0); wcyc(18'h02AAA, 16'h0055, 0);
    wcyc(18'h05555, 16'h00A0, 0); wcyc(18'h00042, 16'hBEEF, 0);
    chk("R12", "start high", start, 1);
    @(negedge clk);
    chk("R12", "start one cycle", start, 0);

    // R7: identification reads
    wcyc(18'h05555, 16'h00AA, 0); wcyc(18'h02AAA, 16'h0055, 0); wcyc(18'h05555, 16'h0090, 0);
    chk("R7", "rd_sel", rd_sel, 1);
    rd_addr = 18'h0; #1 chk("R7", "mfr", rd_data, 16'h00BF);
    rd_addr = 18'h1; #1 chk("R7", "dev", rd_data, 16'h272F);
    rd_addr = 18'h2; #1 chk("R7", "other", rd_data, 16'h0000);

    // R11: busy ignores exit and sequence writes
    wcyc(18'h00000, 16'h00F0, 1);
    chk("R11", "exit ignored, mode", mode, 1);
    wcyc(18'h05555, 16'h00AA, 1); wcyc(18'h02AAA, 16'h0055, 1);
    wcyc(18'h05555, 16'h00A0, 1); wcyc(18'h00077, 16'h5A5A, 1);
    chk("R11", "no start while busy", start, 0);
    chk("R11", "mode kept", mode, 1);
    // R11: an open sequence survives busy writes
    wcyc(18'h05555, 16'h00AA, 0);
    wcyc(18'h01111, 16'h0000, 1);
    wcyc(18'h02AAA, 16'h0055, 0); wcyc(18'h05555, 16'h00A0, 0);
    wcyc(18'h00321, 16'hC0DE, 0);
    chk("R11", "held sequence start", start, 1);
    chk("R11", "held sequence addr", op_addr, 18'h00321);
    chk("R11", "mode after held seq", mode, 1);

    // R10: broken sequence in id mode returns to array
    wcyc(18'h05555, 16'h00AA, 0); wcyc(18'h00000, 16'h0000, 0);
    chk("R10", "abort mode", mode, 0);
    chk("R10", "abort rd_sel", rd_sel, 0);

    // R8: query reads
    wcyc(18'h05555, 16'h00AA, 0); wcyc(18'h02AAA, 16'h0055, 0); wcyc(18'h05555, 16'h0098, 0);
    chk("R8", "rd_sel", rd_sel, 1);
    rd_addr = 18'h10; #1 chk("R8", "q10", rd_data, 16'h0051);
    rd_addr = 18'h11; #1 chk("R8", "q11", rd_data, 16'h0052);
    rd_addr = 18'h12; #1 chk("R8", "q12", rd_data, 16'h0059);
    rd_addr = 18'h13; #1 chk("R8", "q13", rd_data, 16'h0001);
    rd_addr = 18'h27; #1 chk("R8", "q27", rd_data, 16'h0013);
    rd_addr = 18'h05; #1 chk("R8", "q05", rd_data, 16'h0000);

    // R1: reset mid-mode clears everything
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "mode after reset", mode, 0);
    chk("R1", "rd_sel after reset", rd_sel, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule